// File: doc/BRIEF.md
# Standby Mode Wake Controller

This block sequences a processor core into and out of three low-power halt modes. A programmable idle mode stops only the core clock, a light idle mode also gates the peripheral clocks, and a full stop mode additionally asserts a deep-stop indication. Entry always passes through a short window of `WIN_CYC` clock cycles, and the halt state is reached only when that window ends.

Seven wake-capable sources are watched on every clock: a non-maskable request, five external requests and a real-time-clock tick. Every enabled request is latched into a pending vector. In the two deeper modes, a request that lands inside the entry window is only latched: the core still halts, and only a later request wakes it. In programmable idle, any request ends the entry at once. A small priority comparator picks the pending source to serve first. The resolver downstream clears each pending bit by acknowledging its index.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After reset the block is in the run state. `core_clk_en` and `periph_clk_en` are 1, `deep_stop` and `in_window` are 0, `pend_vec` is 0, `top_valid` is 0 and `top_id` is 0.
- R2: In the run state, a `halt_req` with `halt_mode` 0 (programmable idle), 1 (light idle) or 2 (stop) raises `in_window` on the next cycle and holds it for `WIN_CYC` cycles. A `halt_req` with mode code 3 is ignored.
- R3: In the halt state `core_clk_en` is 0. `periph_clk_en` is 1 only for programmable idle. `deep_stop` is 1 only for stop mode.
- R4: In light idle and stop mode, an enabled request sampled on any edge of the entry window, including the first and the last, is latched as pending. It does not wake the core, and the halt state begins on schedule.
- R5: In programmable idle, an enabled request sampled during the entry window returns the block to the run state after that edge.
- R6: An enabled request sampled while halted returns the block to the run state after that edge, and it is added to any request already latched.
- R7: Source index map: bit 0 is the non-maskable request and is always enabled. Bits 1 to 5 are external requests 0 to 4, and bit 6 is the clock tick. Source i (1..6) takes its level from `src_level[3*(i-1)+:3]`. Level 0 disables the source, so that source is neither latched nor able to wake the core.
- R8: A pending bit stays set until `ack_valid` arrives with `ack_id` equal to its index. An acknowledge clears only that bit. A new request on the same source in the same cycle keeps the bit set.
- R9: `top_id` names the pending source that ranks first. The non-maskable request ranks above every level. Otherwise the higher level wins, and on equal levels the lower index wins. When nothing is pending, `top_valid` is 0 and `top_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Request to enter the mode on `halt_mode` |
| halt_mode | input | 2 | 0 programmable idle, 1 light idle, 2 stop, 3 invalid |
| src_req | input | 7 | Wake request per source, sampled each clock |
| src_level | input | 18 | Three-bit priority level of each maskable source |
| ack_valid | input | 1 | Resolver acknowledges one source |
| ack_id | input | 3 | Index of the acknowledged source |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| deep_stop | output | 1 | High while halted in stop mode |
| in_window | output | 1 | High during the entry window |
| pend_vec | output | 7 | Latched pending requests |
| top_valid | output | 1 | A ranked pending source exists |
| top_id | output | 3 | Index of the highest-ranked pending source |

## Verification
The hardest condition to reach is a request that falls on the exact boundary edges of the entry window. These are the first and last window edges, where the request must be latched without waking the core, and the first halted edge, where it must wake the core. The stimulus counts clock edges from the sampled `halt_req` and places one-cycle request pulses on those edges in light idle and in stop mode. It then confirms that the core stays halted until a second request arrives, and that both requests then appear in priority order.

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl #(
  parameter int NUM_EXT = 5,
  parameter int LVL_W   = 3,
  parameter int WIN_CYC = 5,
  localparam int NSRC = NUM_EXT + 2,
  localparam int IDW  = $clog2(NSRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     halt_req,
  input  logic [1:0]               halt_mode,
  input  logic [NSRC-1:0]          src_req,
  input  logic [(NSRC-1)*LVL_W-1:0] src_level,
  input  logic                     ack_valid,
  input  logic [IDW-1:0]           ack_id,
  output logic                     core_clk_en,
  output logic                     periph_clk_en,
  output logic                     deep_stop,
  output logic                     in_window,
  output logic [NSRC-1:0]          pend_vec,
  output logic                     top_valid,
  output logic [IDW-1:0]           top_id
);
  localparam int CNTW = $clog2(WIN_CYC + 1);
  localparam logic [1:0] M_PROG = 2'd0;
  localparam logic [1:0] M_STOP = 2'd2;

  typedef enum logic [1:0] {S_RUN, S_ENTER, S_HALT} st_t;

  st_t             st;
  logic [1:0]      mode_q;
  logic [CNTW-1:0] cnt;
  logic [NSRC-1:0] pend_q, en, inc, ack_mask;
  logic [LVL_W:0]  lvl [NSRC];

  assign en[0]  = 1'b1;
  assign lvl[0] = {1'b1, {LVL_W{1'b0}}};
  for (genvar i = 1; i < NSRC; i++) begin : g_src
    assign lvl[i] = {1'b0, src_level[(i-1)*LVL_W +: LVL_W]};
    assign en[i]  = |src_level[(i-1)*LVL_W +: LVL_W];
  end
  for (genvar i = 0; i < NSRC; i++) begin : g_ack
    assign ack_mask[i] = ack_valid && (ack_id == IDW'(i));
  end

  assign inc = src_req & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      mode_q <= M_PROG;
      cnt    <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_mask) | inc;
      case (st)
        S_RUN:
          if (halt_req && halt_mode != 2'd3) begin
            st     <= S_ENTER;
            mode_q <= halt_mode;
            cnt    <= '0;
          end
        S_ENTER:
          if (mode_q == M_PROG && |inc) st <= S_RUN;
          else if (cnt == CNTW'(WIN_CYC - 1)) st <= S_HALT;
          else cnt <= cnt + 1'b1;
        S_HALT:
          if (|inc) st <= S_RUN;
        default: st <= S_RUN;
      endcase
    end
  end

  assign core_clk_en   = (st != S_HALT);
  assign periph_clk_en = !(st == S_HALT && mode_q != M_PROG);
  assign deep_stop     = (st == S_HALT) && (mode_q == M_STOP);
  assign in_window     = (st == S_ENTER);
  assign pend_vec      = pend_q;

  always_comb begin
    logic [LVL_W:0] best;
    best      = '0;
    top_valid = 1'b0;
    top_id    = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_q[i] && lvl[i] > best) begin
        best      = lvl[i];
        top_valid = 1'b1;
        top_id    = IDW'(i);
      end
    end
  end

  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENTER) |-> (cnt < CNTW'(WIN_CYC)));
  a_r4_window_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENTER && mode_q != M_PROG && |inc) |=> (st != S_RUN));
  a_r5_prog_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENTER && mode_q == M_PROG && |inc) |=> (st == S_RUN));
  a_r6_halt_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT && |inc) |=> (st == S_RUN));
  a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_valid && !(|inc)) |=> $stable(pend_q));
  a_r9_top_pending: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> pend_q[top_id]);
endmodule

// File: tb/tb_standby_wake_ctrl.sv
module tb_standby_wake_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_req = 1'b0, ack_valid = 1'b0;
  logic [1:0] halt_mode = 2'd0;
  logic [6:0] src_req = '0;
  logic [17:0] src_level = '0;
  logic [2:0] ack_id = '0;
  logic core_clk_en, periph_clk_en, deep_stop, in_window, top_valid;
  logic [6:0] pend_vec;
  logic [2:0] top_id;

  standby_wake_ctrl dut (.*);

  always #4 clk = ~clk;

  typedef struct { int cyc; logic [14:0] v; string tag; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  localparam logic [3:0] RUN = 4'b1100, ENT = 4'b1101,
    H_PROG = 4'b0100, H_LIGHT = 4'b0000, H_STOP = 4'b0010;

  function automatic logic [14:0] pk(logic [3:0] c, logic [6:0] p, logic tv, logic [2:0] id);
    return {c, p, tv, id};
  endfunction

  task automatic expect_at(int off, logic [14:0] v, string tag);
    item_t it;
    it.cyc = cyc + off; it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(int id);
    ack_valid = 1'b1; ack_id = 3'(id);
  endtask

  always @(posedge clk) begin
    #2;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      logic [14:0] act;
      it  = q.pop_front();
      act = {core_clk_en, periph_clk_en, deep_stop, in_window, pend_vec, top_valid, top_id};
      checks++;
      if (act !== it.v || it.cyc != cyc) begin
        fails++;
        $display("FAIL %s: actual=%b expected=%b (cycle %0d)", it.tag, act, it.v, it.cyc);
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    src_level = {3'd3, 3'd1, 3'd7, 3'd0, 3'd5, 3'd2};
    step(3);
    rst_n = 1'b1;
    expect_at(1, pk(RUN, 7'b0, 0, 0), "R1 reset state");
    step(2);

    // stop mode, request on last window edge
    halt_req = 1; halt_mode = 2'd2;
    expect_at(1, pk(ENT, 7'b0, 0, 0), "R2 window opens");
    step(); halt_req = 0;
    step(3);
    expect_at(1, pk(ENT, 7'b0, 0, 0), "R2 window still open");
    step();
    src_req = 7'b0000010;
    expect_at(1, pk(H_STOP, 7'b0000010, 1, 1), "R4 last window edge latched, R3 stop");
    step(); src_req = 0;
    expect_at(2, pk(H_STOP, 7'b0000010, 1, 1), "R4 no wake from latched request");
    step(2);
    src_req = 7'b0010000;
    expect_at(1, pk(RUN, 7'b0010010, 1, 4), "R6 later request wakes, R9 level order");
    step(); src_req = 0; ack(4);
    expect_at(1, pk(RUN, 7'b0000010, 1, 1), "R8 ack clears one bit");
    step(); ack(1);
    expect_at(1, pk(RUN, 7'b0, 0, 0), "R8 ack clears last bit");
    step(); ack_valid = 0;
    step(2);

    // light idle, request on first window edge, wake on first halted edge
    halt_req = 1; halt_mode = 2'd1;
    expect_at(1, pk(ENT, 7'b0, 0, 0), "R2 light idle entry");
    step(); halt_req = 0; src_req = 7'b1000000;
    expect_at(1, pk(ENT, 7'b1000000, 1, 6), "R4 first window edge latched");
    step(); src_req = 0;
    step(3);
    expect_at(1, pk(H_LIGHT, 7'b1000000, 1, 6), "R3 light idle gating");
    step(); src_req = 7'b0000001;
    expect_at(1, pk(RUN, 7'b1000001, 1, 0), "R6 first halted edge wakes, R9 non-maskable first");
    step(); src_req = 0; ack(0);
    expect_at(1, pk(RUN, 7'b1000000, 1, 6), "R8 held request served next");
    step(); ack(6);
    expect_at(1, pk(RUN, 7'b0, 0, 0), "R8 clear");
    step(); ack_valid = 0;
    step(2);

    // programmable idle, request inside window wakes
    halt_req = 1; halt_mode = 2'd0;
    expect_at(1, pk(ENT, 7'b0, 0, 0), "R2 prog idle entry");
    step(); halt_req = 0;
    step(); src_req = 7'b0100000;
    expect_at(1, pk(RUN, 7'b0100000, 1, 5), "R5 prog idle window wake");
    step(); src_req = 0;
    step(2);

    // programmable idle full halt, disabled source ignored
    halt_req = 1; halt_mode = 2'd0;
    step(); halt_req = 0;
    step(3);
    expect_at(2, pk(H_PROG, 7'b0100000, 1, 5), "R3 prog idle gating");
    step(2);
    src_req = 7'b0001000;
    expect_at(1, pk(H_PROG, 7'b0100000, 1, 5), "R7 level-0 source ignored");
    step(); src_req = 0;
    step(); src_req = 7'b0000100;
    expect_at(1, pk(RUN, 7'b0100100, 1, 2), "R6 wake from prog idle, R9 level 5 over 1");
    step(); src_req = 0; ack(2);
    expect_at(1, pk(RUN, 7'b0100000, 1, 5), "R8 ack");
    step(); ack(5);
    step(); ack_valid = 0;

    // invalid mode code
    halt_req = 1; halt_mode = 2'd3;
    expect_at(1, pk(RUN, 7'b0, 0, 0), "R2 mode code 3 ignored");
    step(); halt_req = 0;
    step();

    // tie, ack/set collision, ack of idle bit
    src_level[17:15] = 3'd2;
    src_req = 7'b1000010;
    expect_at(1, pk(RUN, 7'b1000010, 1, 1), "R9 equal levels lower index");
    step(); src_req = 7'b1000000; ack(6);
    expect_at(1, pk(RUN, 7'b1000010, 1, 1), "R8 new request beats ack");
    step(); src_req = 0; ack(3);
    expect_at(1, pk(RUN, 7'b1000010, 1, 1), "R8 other bits kept");
    step(); ack(1);
    expect_at(1, pk(RUN, 7'b1000000, 1, 6), "R8 ack one of two");
    step(); ack(6);
    expect_at(1, pk(RUN, 7'b0, 0, 0), "R8 empty again, R9 no top");
    step(); ack_valid = 0;
    step(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule